// File: doc/BRIEF.md
# Pipelined Tree Prefix Scanner

The block takes a batch of `N` words in parallel and returns all `N` inclusive prefix results: output word `i` is the combination of input words `0` through `i`. The words are combined by a balanced binary tree of nodes with a register stage after every level. The tree is used twice per batch. On the way up, every node merges the totals of its two subtrees. On the way down, every node gives each child the combination of everything to the child's left. Because each level is registered, no path through the logic is deeper than one node.

The user places a batch on `data_i` and pulses `start_i`. The block captures the words, runs the upward and downward sweeps, and raises `done_o` for one cycle when `prefix_o` holds the results. Only one batch is in flight at a time. A parameter selects the combining operator. The default is wrapping addition, and bitwise XOR can be chosen instead; zero is the identity for both.

Top module: `prefix_tree_scan`

## Requirements
- R1: While reset is asserted and after its release, until the first start is taken, `busy_o` and `done_o` are 0 and `prefix_o` is all zeros.
- R2: If `start_i` is high at rising edge k while `busy_o` is low, `done_o` is high only in the cycle between edges k+2·log2(N) and k+2·log2(N)+1. With N=8 that is 7 cycles after the start cycle.
- R3: When `done_o` is high, word i of `prefix_o` (bits i·W upward) equals the combination of words 0..i of the captured `data_i`, where word j sits at bits j·W upward.
- R4: `prefix_o` changes only at the edge that raises `done_o`, and it holds its value until the next batch completes.
- R5: `busy_o` rises at the edge that takes a start and falls at the edge that raises `done_o`.
- R6: While `busy_o` is high, a `start_i` pulse and any change on `data_i` have no effect on the result or its timing. The words are captured only at the edge that takes the start.
- R7: With the add operator, every sum wraps modulo 2^W (for example, eight words of all ones give word 7 = 2^W−8).
- R8: With the XOR operator selected, word i of `prefix_o` is the bitwise XOR of input words 0..i.
- R9: A start presented in the cycle in which `done_o` is high is taken, so batches can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a batch; taken only when not busy |
| data_i | input | N·W | N input words, word i at bits i·W upward |
| busy_o | output | 1 | A batch is being processed |
| done_o | output | 1 | One-cycle flag: `prefix_o` holds new results |
| prefix_o | output | N·W | N inclusive prefix words, word i at bits i·W upward |

## Verification
The properties assume that reset is held across at least one rising edge, so that history-based checks begin from the reset values, and that `N` is a power of two no smaller than 4. They also assume `start_i` and `data_i` change only away from the rising edge. The bench meets these assumptions by holding reset for several edges and driving every input on the falling edge. Its busy-time start pulses and data changes fall strictly inside the window in which the block must ignore them.

// File: rtl/prefix_tree_pkg.sv
package prefix_tree_pkg;

  typedef enum logic [0:0] {
    OP_ADD = 1'b0,
    OP_XOR = 1'b1
  } scan_op_e;

  // words of upward sums kept at level l (level 1 full, higher levels drop the unused last node)
  function automatic int unsigned up_size(input int unsigned n, input int unsigned l);
    return (l == 1) ? n / 2 : (n >> l) - 1;
  endfunction

  function automatic int unsigned up_off(input int unsigned n, input int unsigned l);
    int unsigned s;
    s = 0;
    for (int unsigned m = 1; m < l; m++) s += up_size(n, m);
    return s;
  endfunction

  function automatic int unsigned dn_off(input int unsigned n, input int unsigned l);
    int unsigned s;
    s = 0;
    for (int unsigned m = 1; m < l; m++) s += n >> m;
    return s;
  endfunction

endpackage

// File: rtl/prefix_op_cell.sv
module prefix_op_cell
  import prefix_tree_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter scan_op_e    OP = OP_ADD
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);

  if (OP == OP_XOR) begin : g_xor
    assign y_o = a_i ^ b_i;
  end else begin : g_add
    assign y_o = a_i + b_i;
  end

endmodule

// File: rtl/prefix_up_stage.sv
module prefix_up_stage
  import prefix_tree_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned CNT = 4,
  parameter scan_op_e    OP  = OP_ADD
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [2*CNT-1:0][W-1:0]     kid_i,
  output logic [CNT-1:0][W-1:0]       sum_o
);

  logic [CNT-1:0][W-1:0] sum_d;

  for (genvar k = 0; k < CNT; k++) begin : g_node
    prefix_op_cell #(.W(W), .OP(OP)) u_op (
      .a_i(kid_i[2*k]),
      .b_i(kid_i[2*k+1]),
      .y_o(sum_d[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= sum_d;
  end

endmodule

// File: rtl/prefix_down_stage.sv
module prefix_down_stage
  import prefix_tree_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned CNT = 2,
  parameter scan_op_e    OP  = OP_ADD
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [CNT-1:0][W-1:0]       par_i,
  input  logic [CNT-1:0][W-1:0]       left_i,
  output logic [2*CNT-1:0][W-1:0]     kid_o
);

  logic [2*CNT-1:0][W-1:0] kid_d;

  for (genvar k = 0; k < CNT; k++) begin : g_node
    assign kid_d[2*k] = par_i[k];
    // right child sees everything left of it: parent prefix plus left subtree
    prefix_op_cell #(.W(W), .OP(OP)) u_op (
      .a_i(par_i[k]),
      .b_i(left_i[k]),
      .y_o(kid_d[2*k+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kid_o <= '0;
    else         kid_o <= kid_d;
  end

endmodule

// File: rtl/prefix_seq_ctrl.sv
module prefix_seq_ctrl #(
  parameter int unsigned LAT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic fire_o
);

  localparam int unsigned CW = $clog2(LAT);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign load_o = start_i && !busy_q;
  assign fire_o = busy_q && (cnt_q == CW'(LAT - 1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (fire_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/prefix_tree_scan.sv
module prefix_tree_scan
  import prefix_tree_pkg::*;
#(
  parameter int unsigned N  = 8,   // power of two, at least 4
  parameter int unsigned W  = 16,
  parameter scan_op_e    OP = OP_ADD
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N*W-1:0] data_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [N*W-1:0] prefix_o
);

  localparam int unsigned L    = $clog2(N);
  localparam int unsigned LAT  = 2 * L;
  localparam int unsigned UTOT = up_off(N, L);
  localparam int unsigned DTOT = dn_off(N, L);
  localparam int unsigned HALF = N / 2;

  logic                     load, fire;
  logic [N-1:0][W-1:0]      leaf_q;
  logic [UTOT-1:0][W-1:0]   up_flat;
  logic [DTOT-1:0][W-1:0]   dn_flat;
  logic [N-1:0][W-1:0]      out_d, out_q;
  logic                     done_q;

  prefix_seq_ctrl #(.LAT(LAT)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .busy_o (busy_o),
    .load_o (load),
    .fire_o (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   leaf_q <= '0;
    else if (load) leaf_q <= data_i;
  end

  // upward sweep: levels 1 .. L-1 (root total is never needed)
  for (genvar l = 1; l < L; l++) begin : g_up
    localparam int unsigned CNT = up_size(N, l);
    localparam int unsigned OFS = up_off(N, l);
    if (l == 1) begin : g_first
      prefix_up_stage #(.W(W), .CNT(CNT), .OP(OP)) u_stage (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .kid_i (leaf_q),
        .sum_o (up_flat[OFS +: CNT])
      );
    end else begin : g_inner
      prefix_up_stage #(.W(W), .CNT(CNT), .OP(OP)) u_stage (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .kid_i (up_flat[up_off(N, l-1) +: 2*CNT]),
        .sum_o (up_flat[OFS +: CNT])
      );
    end
  end

  // downward sweep: node at level l feeds its children at level l-1
  for (genvar l = 2; l <= L; l++) begin : g_dn
    localparam int unsigned CNT  = N >> l;
    localparam int unsigned LOFS = up_off(N, l-1);
    localparam int unsigned KOFS = dn_off(N, l-1);
    logic [CNT-1:0][W-1:0] par_w, left_w;

    if (l == L) begin : g_root
      assign par_w = '0;  // identity into the root
    end else begin : g_mid
      assign par_w = dn_flat[dn_off(N, l) +: CNT];
    end

    for (genvar k = 0; k < CNT; k++) begin : g_left
      assign left_w[k] = up_flat[LOFS + 2*k];
    end

    prefix_down_stage #(.W(W), .CNT(CNT), .OP(OP)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .par_i (par_w),
      .left_i(left_w),
      .kid_o (dn_flat[KOFS +: 2*CNT])
    );
  end

  // last level turns exclusive prefixes into inclusive ones, one node deep
  for (genvar k = 0; k < HALF; k++) begin : g_out
    prefix_op_cell #(.W(W), .OP(OP)) u_even (
      .a_i(dn_flat[k]),
      .b_i(leaf_q[2*k]),
      .y_o(out_d[2*k])
    );
    prefix_op_cell #(.W(W), .OP(OP)) u_odd (
      .a_i(dn_flat[k]),
      .b_i(up_flat[k]),
      .y_o(out_d[2*k+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire;
      if (fire) out_q <= out_d;
    end
  end

  assign prefix_o = out_q;
  assign done_o   = done_q;

endmodule

// File: rtl/prefix_tree_scan_chk.sv
module prefix_tree_scan_chk #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [N*W-1:0] data_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [N*W-1:0] prefix_o
);

  localparam int unsigned LAT = 2 * $clog2(N);
  localparam int unsigned CW  = $clog2(LAT + 2) + 1;

  logic [CW-1:0] lat_q;
  logic [W-1:0]  first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q   <= '0;
      first_q <= '0;
    end else if (start_i && !busy_o) begin
      lat_q   <= CW'(1);
      first_q <= data_i[W-1:0];
    end else if (busy_o) begin
      lat_q   <= lat_q + 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R2
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == CW'(LAT + 1)));  // R2
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);  // R5
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);  // R5
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(prefix_o));  // R4
  AST_FIRST_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (prefix_o[W-1:0] == first_q));  // R6

endmodule

bind prefix_tree_scan prefix_tree_scan_chk #(.N(N), .W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .data_i  (data_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .prefix_o(prefix_o)
);

// File: tb/prefix_tree_scan_tb_top.sv
`timescale 1ns/1ps
module prefix_tree_scan_tb_top;
  import prefix_tree_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // main config: N=8, W=16, add
  logic         start_m = 1'b0;
  logic [127:0] data_m  = '0;
  logic         busy_m, done_m;
  logic [127:0] pre_m;

  // small config: N=4, W=2, add and xor side by side
  logic       start_s = 1'b0;
  logic [7:0] data_s  = '0;
  logic       busy_a, done_a, busy_x, done_x;
  logic [7:0] pre_a, pre_x;

  int n_chk  = 0;
  int n_fail = 0;

  prefix_tree_scan #(.N(8), .W(16), .OP(OP_ADD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_m), .data_i(data_m),
    .busy_o(busy_m), .done_o(done_m), .prefix_o(pre_m)
  );
  prefix_tree_scan #(.N(4), .W(2), .OP(OP_ADD)) dut_s_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s), .data_i(data_s),
    .busy_o(busy_a), .done_o(done_a), .prefix_o(pre_a)
  );
  prefix_tree_scan #(.N(4), .W(2), .OP(OP_XOR)) dut_x_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s), .data_i(data_s),
    .busy_o(busy_x), .done_o(done_x), .prefix_o(pre_x)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] ref_main(input logic [127:0] d);
    logic [15:0]  acc;
    logic [127:0] r;
    acc = '0;
    r   = '0;
    for (int i = 0; i < 8; i++) begin
      acc = acc + d[i*16 +: 16];
      r[i*16 +: 16] = acc;
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_small(input logic [7:0] d, input bit use_xor);
    logic [1:0] acc;
    logic [7:0] r;
    acc = '0;
    r   = '0;
    for (int i = 0; i < 4; i++) begin
      acc = use_xor ? (acc ^ d[i*2 +: 2]) : (acc + d[i*2 +: 2]);
      r[i*2 +: 2] = acc;
    end
    return r;
  endfunction

  // called on a falling edge; returns on the falling edge where done is high
  task automatic run_main(input logic [127:0] d, input bit poke, input string tag);
    data_m  = d;
    start_m = 1'b1;
    @(negedge clk);
    start_m = 1'b0;
    data_m  = ~d;  // R6: changes after capture are ignored
    for (int c = 1; c <= 7; c++) begin
      if (c > 1) @(negedge clk);
      if (poke && c == 3) begin
        start_m = 1'b1;  // R6: start while busy
        data_m  = {$urandom, $urandom, $urandom, $urandom};
      end
      if (poke && c == 4) start_m = 1'b0;
      chk("R2 done timing", 128'(done_m), 128'(c == 7));
      chk("R5 busy window", 128'(busy_m), 128'(c < 7));
    end
    chk(tag, pre_m, ref_main(d));
  endtask

  task automatic run_small(input logic [7:0] d);
    data_s  = d;
    start_s = 1'b1;
    @(negedge clk);
    start_s = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 small done low early", 128'(done_a), 128'(0));
    @(negedge clk);
    chk("R2 small done", 128'(done_a), 128'(1));
    chk("R3 small add prefix", 128'(pre_a), 128'(ref_small(d, 1'b0)));
    chk("R8 xor prefix", 128'(pre_x), 128'(ref_small(d, 1'b1)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [127:0] d, keep;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 128'(busy_m), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy", 128'(busy_m), 128'(0));
    chk("R1 done", 128'(done_m), 128'(0));
    chk("R1 prefix", pre_m, 128'(0));
    chk("R1 small prefix", 128'({pre_a, pre_x}), 128'(0));

    // directed: ascending words
    for (int i = 0; i < 8; i++) d[i*16 +: 16] = 16'(i + 1);
    run_main(d, 1'b0, "R3 ascending");
    keep = d;
    repeat (3) @(negedge clk);
    chk("R4 result held", pre_m, ref_main(keep));
    chk("R4 done cleared", 128'(done_m), 128'(0));

    // wrap
    d = {128{1'b1}};
    run_main(d, 1'b0, "R7 wrap all ones");
    chk("R7 top word", 128'(pre_m[112 +: 16]), 128'(16'hFFF8));
    chk("R7 first word", 128'(pre_m[15:0]), 128'(16'hFFFF));
    @(negedge clk);

    // start and data changes while busy
    d = {$urandom, $urandom, $urandom, $urandom};
    run_main(d, 1'b1, "R6 busy start ignored");
    @(negedge clk);

    // back to back: next start in the done cycle
    d = {$urandom, $urandom, $urandom, $urandom};
    run_main(d, 1'b0, "R3 first of pair");
    d = {$urandom, $urandom, $urandom, $urandom};
    run_main(d, 1'b0, "R9 back to back");

    // random sweep with varying gaps
    for (int t = 0; t < 200; t++) begin
      d = {$urandom, $urandom, $urandom, $urandom};
      run_main(d, (t % 7) == 3, "R3 random");
      repeat (t % 3) @(negedge clk);
    end

    // exhaustive sweep of small configs, back to back
    for (int v = 0; v < 256; v++) run_small(8'(v));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule